// File: doc/BRIEF.md
# Speculative Load Snoop Violation Queue

This block keeps a record of every load that a core has sent down its pipeline and not yet retired. Loads are entered in program order with a tag. Each entry later takes the address the load read once it executes. Entries leave from the oldest end when the core retires them. While a load has read memory but not retired, its value may be stale. The block therefore compares the line address of every write that another agent makes visible (a coherence snoop) against the executed, unretired entries.

When a snoop hits, the block raises a one-cycle flush request carrying the tag of the oldest hit load. In the same cycle it drops that entry and everything younger, so the core can restart from that load. A pause input lets software-hinted spin loops serialize their loads. While pause is held and any load is still outstanding, the block asserts an issue stall. Each spin iteration then waits for the previous load to retire, which shrinks the window in which a snoop can catch a speculative read.

Top module: `spec_load_snoop_queue`

## Requirements
- R1: After reset the queue is empty: `flushValid` is low and `issueStall` is low, even with `pauseReq` high.
- R2: The queue holds 8 loads in program order. `issueStall` is high while 8 loads are held, and an `allocValid` presented while `issueStall` is high is ignored.
- R3: When `commitReq` is high and the oldest entry has executed, exactly that one entry retires that cycle. A `commitReq` while the oldest entry has not executed changes nothing.
- R4: A snoop matches an entry only when the entry has executed and its address equals `snoopAddr` in bits [ADDR_W-1:6]. Bits [5:0] are ignored.
- R5: On a match, `flushValid` is high for exactly the next cycle. `flushTag` carries the tag of the oldest matching entry in program order.
- R6: In the snoop cycle, the matching entry and all younger entries are discarded, and an allocation offered in that cycle is dropped.
- R7: A snoop that matches no executed entry causes no flush, even when entries executed out of program order.
- R8: If the oldest entry retires in the same cycle as a snoop that matches it, the retirement wins and that entry causes no flush. A younger matching entry still flushes.
- R9: `issueStall` is high whenever `pauseReq` is high and at least one load is held. It is low with `pauseReq` high once the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Enter a new load at the young end |
| allocTag | input | TAG_W | Tag of the new load |
| exeValid | input | 1 | A held load has executed |
| exeTag | input | TAG_W | Tag of the executed load |
| exeAddr | input | ADDR_W | Address the executed load read |
| commitReq | input | 1 | Retire the oldest load if it has executed |
| snoopValid | input | 1 | External write observed |
| snoopAddr | input | ADDR_W | Address of the external write |
| pauseReq | input | 1 | Serialize load issue |
| issueStall | output | 1 | New loads must not be entered |
| flushValid | output | 1 | One-cycle flush request |
| flushTag | output | TAG_W | Tag of the oldest violating load |

## Verification
A corrupted head pointer or occupancy count shows up first at `issueStall`. The queue then reports full or non-empty at the wrong time, within a few cycles of a pause or a burst of allocations. A wrong executed flag or stored address shows up at the first snoop to that line, either as a missing flush or as a spurious one. A wrong age search shows up as a `flushTag` naming a younger load. A bad truncation shows up at the next snoop or allocation, because the discarded entries then flush or occupy slots where they should not.

// File: rtl/slq_pkg.sv
package slq_pkg;
  localparam int SLQ_DEPTH = 8;
  localparam int SLQ_IDX_W = $clog2(SLQ_DEPTH);
  localparam int SLQ_CNT_W = SLQ_IDX_W + 1;

  typedef logic [SLQ_IDX_W-1:0] slotIdx_t;
  typedef logic [SLQ_DEPTH-1:0] slotMask_t;

  typedef struct packed {
    logic      allocEn;
    slotIdx_t  allocIdx;
    logic      commitEn;
    slotIdx_t  headIdx;
    logic      flushEn;
    slotIdx_t  flushIdx;
    slotMask_t killMask;
  } slqStrobe_t;
endpackage

// File: rtl/slq_ctrl.sv
module slq_ctrl
  import slq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       allocValid,
  input  logic       commitReq,
  input  logic       pauseReq,
  input  logic       snoopValid,
  input  slotMask_t  execVec,
  input  slotMask_t  lineHit,
  output slqStrobe_t strb,
  output logic       issueStall,
  output logic       flushValid
);
  localparam logic [SLQ_CNT_W-1:0] FULL_CNT = SLQ_CNT_W'(SLQ_DEPTH);

  slotIdx_t              head, headNext;
  logic [SLQ_CNT_W-1:0]  count, countNext;
  logic [SLQ_CNT_W-1:0]  firstOff;
  logic                  found, isFull, isEmpty;
  slotMask_t             candVec;

  always_comb begin
    isFull     = (count == FULL_CNT);
    isEmpty    = (count == '0);
    issueStall = isFull | (pauseReq & ~isEmpty);
  end

  // oldest-first search over snoop hits, head entry excluded when it retires now
  always_comb begin
    strb          = '0;
    strb.headIdx  = head;
    strb.commitEn = commitReq & ~isEmpty & execVec[head];
    candVec       = lineHit;
    if (strb.commitEn) candVec[head] = 1'b0;
    found    = 1'b0;
    firstOff = '0;
    for (int i = SLQ_DEPTH - 1; i >= 0; i--) begin
      if (candVec[slotIdx_t'(head + slotIdx_t'(i))]) begin
        found    = 1'b1;
        firstOff = SLQ_CNT_W'(i);
      end
    end
    strb.flushEn  = snoopValid & found;
    strb.flushIdx = slotIdx_t'(head + firstOff[SLQ_IDX_W-1:0]);
    for (int i = 0; i < SLQ_DEPTH; i++) begin
      strb.killMask[i] = strb.flushEn &
        ({1'b0, slotIdx_t'(slotIdx_t'(i) - head)} >= firstOff);
    end
    strb.allocEn  = allocValid & ~issueStall & ~strb.flushEn;
    strb.allocIdx = slotIdx_t'(head + count[SLQ_IDX_W-1:0]);
  end

  always_comb begin
    headNext = strb.commitEn ? slotIdx_t'(head + 1'b1) : head;
    if (strb.flushEn)
      countNext = firstOff - SLQ_CNT_W'(strb.commitEn);
    else
      countNext = count + SLQ_CNT_W'(strb.allocEn) - SLQ_CNT_W'(strb.commitEn);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      head       <= '0;
      count      <= '0;
      flushValid <= 1'b0;
    end else begin
      head       <= headNext;
      count      <= countNext;
      flushValid <= strb.flushEn;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT); // R2
  AST_NO_ALLOC_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (count == FULL_CNT) |-> !strb.allocEn); // R2
  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pauseReq && count != '0) |=> count <= $past(count)); // R9
  AST_FLUSH_SHRINK: assert property (@(posedge clk) disable iff (!rstN)
    strb.flushEn |=> count < $past(count)); // R6
endmodule

// File: rtl/slq_data.sv
module slq_data
  import slq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int TAG_W    = 6,
  parameter int LINE_LSB = 6
)(
  input  logic              clk,
  input  logic              rstN,
  input  slqStrobe_t        strb,
  input  logic [TAG_W-1:0]  allocTag,
  input  logic              exeValid,
  input  logic [TAG_W-1:0]  exeTag,
  input  logic [ADDR_W-1:0] exeAddr,
  input  logic [ADDR_W-1:0] snoopAddr,
  output slotMask_t         execVec,
  output slotMask_t         lineHit,
  output logic [TAG_W-1:0]  flushTag
);
  slotMask_t         validVec;
  logic [TAG_W-1:0]  tagArr  [SLQ_DEPTH];
  logic [ADDR_W-1:0] addrArr [SLQ_DEPTH];

  for (genvar g = 0; g < SLQ_DEPTH; g++) begin : gEntry
    logic killNow, retireNow, allocNow, exeHit;

    always_comb begin
      allocNow  = strb.allocEn & (strb.allocIdx == slotIdx_t'(g));
      killNow   = strb.killMask[g];
      retireNow = strb.commitEn & (strb.headIdx == slotIdx_t'(g));
      exeHit    = exeValid & validVec[g] & ~execVec[g] & (tagArr[g] == exeTag);
      lineHit[g] = validVec[g] & execVec[g] &
                   (((addrArr[g] ^ snoopAddr) >> LINE_LSB) == '0);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validVec[g] <= 1'b0;
        execVec[g]  <= 1'b0;
        tagArr[g]   <= '0;
        addrArr[g]  <= '0;
      end else if (allocNow) begin
        validVec[g] <= 1'b1;
        execVec[g]  <= 1'b0;
        tagArr[g]   <= allocTag;
      end else if (killNow || retireNow) begin
        validVec[g] <= 1'b0;
        execVec[g]  <= 1'b0;
      end else if (exeHit) begin
        execVec[g]  <= 1'b1;
        addrArr[g]  <= exeAddr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             flushTag <= '0;
    else if (strb.flushEn) flushTag <= tagArr[strb.flushIdx];
  end

  AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rstN)
    strb.allocEn |-> !validVec[strb.allocIdx]); // R2
  AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitEn |=> !validVec[$past(strb.headIdx)]); // R3
  AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.flushEn |=> !validVec[$past(strb.flushIdx)]); // R6
  AST_HIT_EXECUTED: assert property (@(posedge clk) disable iff (!rstN)
    (lineHit & ~execVec) == '0); // R4
endmodule

// File: rtl/spec_load_snoop_queue.sv
module spec_load_snoop_queue
  import slq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int TAG_W    = 6,
  parameter int LINE_LSB = 6
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic [TAG_W-1:0]  allocTag,
  input  logic              exeValid,
  input  logic [TAG_W-1:0]  exeTag,
  input  logic [ADDR_W-1:0] exeAddr,
  input  logic              commitReq,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic              pauseReq,
  output logic              issueStall,
  output logic              flushValid,
  output logic [TAG_W-1:0]  flushTag
);
  slqStrobe_t strb;
  slotMask_t  execVec, lineHit;

  slq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .commitReq(commitReq),
    .pauseReq(pauseReq), .snoopValid(snoopValid), .execVec(execVec),
    .lineHit(lineHit), .strb(strb), .issueStall(issueStall),
    .flushValid(flushValid)
  );

  slq_data #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .LINE_LSB(LINE_LSB)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .allocTag(allocTag),
    .exeValid(exeValid), .exeTag(exeTag), .exeAddr(exeAddr),
    .snoopAddr(snoopAddr), .execVec(execVec), .lineHit(lineHit),
    .flushTag(flushTag)
  );
endmodule

// File: tb/spec_load_snoop_queue_bench.sv
module spec_load_snoop_queue_bench;
  localparam int CLK_P = 10;

  typedef struct {
    logic [5:0]  tag;
    bit          ex;
    logic [31:0] addr;
  } ment_t;

  logic clk = 1'b0, rstN = 1'b0;
  logic allocValid = 0, exeValid = 0, commitReq = 0, snoopValid = 0, pauseReq = 0;
  logic [5:0]  allocTag = '0, exeTag = '0;
  logic [31:0] exeAddr = '0, snoopAddr = '0;
  logic        issueStall, flushValid;
  logic [5:0]  flushTag;

  ment_t mq[$];
  bit    expFlushV = 0;
  logic [5:0] expFlushTag = '0;
  int checks = 0, errors = 0;
  string curReq = "R1";
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  spec_load_snoop_queue u_spec_load_snoop_queue (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocTag(allocTag),
    .exeValid(exeValid), .exeTag(exeTag), .exeAddr(exeAddr),
    .commitReq(commitReq), .snoopValid(snoopValid), .snoopAddr(snoopAddr),
    .pauseReq(pauseReq), .issueStall(issueStall), .flushValid(flushValid),
    .flushTag(flushTag)
  );

  function automatic logic [31:0] lineAddr(int n, int off);
    return 32'((n << 6) | (off & 63));
  endfunction

  task automatic modelStep();
    int  first;
    bit  doCommit, stallNow;
    stallNow = (mq.size() == 8) || (pauseReq && mq.size() > 0);
    doCommit = commitReq && mq.size() > 0 && mq[0].ex;
    first = -1;
    if (snoopValid)
      for (int i = 0; i < mq.size(); i++) begin
        if (i == 0 && doCommit) continue;
        if (first < 0 && mq[i].ex && (mq[i].addr >> 6) == (snoopAddr >> 6)) first = i;
      end
    expFlushV = (first >= 0);
    if (first >= 0) expFlushTag = mq[first].tag;
    if (exeValid)
      for (int i = 0; i < mq.size(); i++)
        if (!mq[i].ex && mq[i].tag == exeTag) begin
          mq[i].ex = 1;
          mq[i].addr = exeAddr;
        end
    if (first >= 0) while (mq.size() > first) void'(mq.pop_back());
    if (doCommit) void'(mq.pop_front());
    if (allocValid && !stallNow && first < 0) mq.push_back('{allocTag, 1'b0, 32'd0});
  endtask

  task automatic checkBit(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0b exp=%0b", curReq, what, act, exp);
    end
  endtask

  task automatic compareOutputs();
    bit expStall;
    expStall = (mq.size() == 8) || (pauseReq && mq.size() > 0);
    checkBit("issueStall", issueStall, expStall);
    checkBit("flushValid", flushValid, expFlushV);
    if (expFlushV) begin
      checks++;
      if (flushTag !== expFlushTag) begin
        errors++;
        $display("FAIL %s flushTag act=%0d exp=%0d", curReq, flushTag, expFlushTag);
      end
    end
  endtask

  // inputs already set at the falling edge; compare, then advance one clock
  task automatic tick();
    #1 compareOutputs();
    @(posedge clk);
    modelStep();
    @(negedge clk);
  endtask

  task automatic idle();
    allocValid = 0; exeValid = 0; commitReq = 0; snoopValid = 0;
  endtask

  task automatic doAlloc(int t);
    idle(); allocValid = 1; allocTag = 6'(t); tick();
  endtask

  task automatic doExe(int t, logic [31:0] a);
    idle(); exeValid = 1; exeTag = 6'(t); exeAddr = a; tick();
  endtask

  task automatic doSnoop(logic [31:0] a, bit withCommit, bit withAlloc, int t);
    idle(); snoopValid = 1; snoopAddr = a; commitReq = withCommit;
    allocValid = withAlloc; allocTag = 6'(t); tick();
  endtask

  task automatic doCommit();
    idle(); commitReq = 1; tick();
  endtask

  task automatic expectFlush(string req, int tagExp);
    idle(); #1;
    checks++;
    if (flushValid !== 1'b1 || flushTag !== 6'(tagExp)) begin
      errors++;
      $display("FAIL %s flush act=%0b/%0d exp=1/%0d", req, flushValid, flushTag, tagExp);
    end
    tick();
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int nextTag;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: empty after reset, stall stays low under pause
    curReq = "R1"; pauseReq = 1; idle(); tick(); pauseReq = 0; tick();

    // R2: fill to eight, ninth is ignored
    curReq = "R2";
    for (int t = 1; t <= 8; t++) doAlloc(t);
    doAlloc(9);
    idle(); tick();

    // R3: commit blocked until the head has executed
    curReq = "R3";
    doCommit();
    doExe(2, lineAddr(2, 0));
    doCommit();
    doExe(1, lineAddr(1, 4));
    doCommit();
    idle(); tick();

    // R7: snoops against unexecuted or unrelated lines
    curReq = "R7";
    doSnoop(lineAddr(5, 0), 0, 0, 0);
    doExe(4, lineAddr(4, 8));
    doSnoop(lineAddr(9, 1), 0, 0, 0);

    // R4 / R6: offset within the line ignored; younger entries and the allocation dropped
    curReq = "R4";
    doSnoop(lineAddr(4, 42), 0, 1, 20);
    expectFlush("R4", 4);
    curReq = "R6";
    doExe(5, lineAddr(3, 0));
    doSnoop(lineAddr(3, 0), 0, 0, 0);

    // R8: head retires while its line is snooped
    curReq = "R8";
    doSnoop(lineAddr(2, 17), 1, 0, 0);
    idle(); tick();

    // R5: oldest of two matching entries executed out of order
    curReq = "R5";
    doAlloc(10); doAlloc(11); doAlloc(12);
    doExe(12, lineAddr(7, 0));
    doExe(11, lineAddr(7, 60));
    doExe(10, lineAddr(6, 0));
    doSnoop(lineAddr(7, 3), 0, 0, 0);
    expectFlush("R5", 11);

    // R8: head retires, younger match still flushes
    curReq = "R8";
    doExe(3, lineAddr(6, 9));
    doSnoop(lineAddr(6, 1), 1, 0, 0);
    expectFlush("R8", 10);

    // R9: pause serializes issue
    curReq = "R9";
    doAlloc(13);
    pauseReq = 1;
    doAlloc(14);
    doExe(13, lineAddr(1, 0));
    doCommit();
    doAlloc(15);
    idle(); tick();
    doExe(15, lineAddr(1, 0));
    doCommit();
    pauseReq = 0;
    idle(); tick();

    // R5: mixed random traffic against the model
    curReq = "R5";
    nextTag = 16;
    for (int c = 0; c < 600; c++) begin
      idle();
      pauseReq   = (($urandom % 8) == 0);
      allocValid = $urandom % 2;
      allocTag   = 6'(nextTag);
      nextTag++;
      exeValid   = $urandom % 2;
      exeTag     = 6'(nextTag - 1 - int'($urandom % 10));
      exeAddr    = lineAddr(int'($urandom % 4), int'($urandom % 64));
      commitReq  = ($urandom % 3) == 0;
      snoopValid = ($urandom % 4) == 0;
      snoopAddr  = lineAddr(int'($urandom % 4), int'($urandom % 64));
      tick();
    end
    idle(); pauseReq = 0; tick();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule